// File: doc/BRIEF.md
# Command Frame Manchester Encoder

This block turns a parallel command word into a line-coded serial chip stream. When a start strobe is accepted it assembles a frame of a fixed header pattern, the data word and a run of stop bits. It then sends the frame one bit at a time, most significant bit first, and splits every bit into two Manchester chips. The chip length is counted in clock cycles and latched when the frame starts, so a bit lasts two chip lengths.

Beside the chip stream the block gives a strobe on the first cycle of each chip and a busy flag that covers the whole frame. It also gives a one-cycle done pulse after the last chip. A signed two-bit level follows the current chip, so a frequency-shift modulator downstream can take it as its ±1 drive without further decoding. The header, data and stop widths and the header pattern are compile-time parameters.

Top module: `cmd_manchester_tx`

## Requirements
- R1: While reset is held and in the first cycle after it, busy_o, done_o, chip_stb_o and chip_o are 0 and level_o is 0.
- R2: A frame is the header pattern `HDR_PAT` (its MSB first), then `data_i` MSB first, then `STP_W` bits of value 1. The frame is F = HDR_W + DAT_W + STP_W bits long and gives exactly 2F chips.
- R3: A bit of value 1 is sent as chip 1 followed by chip 0. A bit of value 0 is sent as chip 0 followed by chip 1.
- R4: Each chip lasts P clock cycles, where P is `chip_len_i` sampled in the cycle the start is accepted. A sampled value of 0 is treated as 1.
- R5: chip_stb_o is 1 only in the first cycle of each chip, so it pulses 2F times per frame.
- R6: While busy, level_o is +1 (2'b01) when chip_o is 1 and -1 (2'b11) when chip_o is 0. While idle, level_o is 0.
- R7: A start is accepted in a cycle where start_i is 1 and busy_o is 0. The first chip and busy_o appear in the next cycle, and busy_o stays 1 until the last chip has ended.
- R8: A start_i pulse while busy_o is 1 is ignored. The frame being sent keeps its data and its chip length.
- R9: done_o is 1 for exactly the one cycle after the last chip, with busy_o 0 in that cycle. A start in that cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request to send a frame |
| data_i | input | DAT_W | Command word, sampled on accept |
| chip_len_i | input | CNT_W | Chip length in clock cycles, sampled on accept |
| chip_o | output | 1 | Current Manchester chip |
| chip_stb_o | output | 1 | First cycle of a chip |
| level_o | output | 2 | Signed level: +1, -1, or 0 when idle |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle pulse after the last chip |

## Verification
The hardest case to reach from the ports is a start that arrives while a frame is still being sent. The bench raises start_i mid-frame with an inverted word and a longer chip length. It then checks, chip by chip, that the running frame keeps both its content and its timing. A second hard case is a new frame that begins in the exact done cycle. The bench covers it by chaining frames with no idle cycle between them. It also sweeps every data value at two chip lengths, and adds frames at lengths 0, 3 and 5.

// File: rtl/cmtx_pkg.sv
// Shared types and helpers for the command frame Manchester encoder.
// Assumes: the chip value is derived from the frame bit and the bit half.
package cmtx_pkg;
    typedef enum logic {PH_FIRST = 1'b0, PH_SECOND = 1'b1} half_e;

    // Manchester coding: a 1 goes high then low, a 0 goes low then high
    function automatic logic line_chip(input logic bit_v, input half_e ph);
        return bit_v ^ (ph == PH_SECOND);
    endfunction

    // Signed level for a chip: +1 for 1, -1 for 0
    function automatic logic signed [1:0] chip_level(input logic chip);
        return chip ? 2'sb01 : 2'sb11;
    endfunction
endpackage

// File: rtl/cmtx_frame_builder.sv
// Assembles header, data and stop bits into one frame vector, MSB first.
// Assumes: the header is constant and every stop bit is 1.
module cmtx_frame_builder #(
    parameter int HDR_W = 4,
    parameter int DAT_W = 8,
    parameter int STP_W = 2,
    parameter logic [HDR_W-1:0] HDR_PAT = '1,
    localparam int FRAME_W = HDR_W + DAT_W + STP_W
) (
    input  logic [DAT_W-1:0]   data_i,
    output logic [FRAME_W-1:0] frame_o
);
    logic [STP_W-1:0] stop_bits;

    // Stop field, one generated bit per stop position
    for (genvar g = 0; g < STP_W; g++) begin : g_stop
        assign stop_bits[g] = 1'b1;
    end

    // Frame concatenation: header sits in the top bits so it leaves first
    assign frame_o = {HDR_PAT, data_i, stop_bits};
endmodule

// File: rtl/cmtx_chip_timer.sv
// Counts the cycles of each chip and flags the first and last cycle.
// Assumes: load_i and run_i are never high in the same cycle.
module cmtx_chip_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] len_i,
    input  logic             run_i,
    output logic             first_o,
    output logic             last_o
);
    logic [CNT_W-1:0] len_q;
    logic [CNT_W-1:0] cnt_q;

    // Latch the chip length at frame start, forcing 0 up to 1
    always_ff @(posedge clk) begin
        if (!rst_n)      len_q <= CNT_W'(1);
        else if (load_i) len_q <= (len_i == '0) ? CNT_W'(1) : len_i;
    end

    // Cycle counter inside a chip, cleared at load and at chip end
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (load_i) cnt_q <= '0;
        else if (run_i)  cnt_q <= last_o ? '0 : cnt_q + CNT_W'(1);
    end

    // Chip boundary flags
    always_comb begin
        first_o = run_i && (cnt_q == '0);
        last_o  = run_i && (cnt_q == len_q - CNT_W'(1));
    end
endmodule

// File: rtl/cmtx_sequencer.sv
// Walks the frame bit by bit and half by half, and owns busy and done.
// Assumes: chip_last_i marks the final cycle of the current chip.
module cmtx_sequencer
    import cmtx_pkg::*;
#(
    parameter int FRAME_W = 14,
    localparam int IDX_W = (FRAME_W > 1) ? $clog2(FRAME_W) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [FRAME_W-1:0] frame_i,
    input  logic               chip_last_i,
    output logic               accept_o,
    output logic               busy_o,
    output logic               done_o,
    output logic               bit_o,
    output half_e              phase_o
);
    logic [FRAME_W-1:0] shreg_q;
    logic [IDX_W-1:0]   idx_q;
    logic               bit_end;
    logic               frame_end;

    // Boundary decode for the current bit and the whole frame
    always_comb begin
        accept_o  = start_i && !busy_o;
        bit_end   = busy_o && chip_last_i && (phase_o == PH_SECOND);
        frame_end = bit_end && (idx_q == IDX_W'(FRAME_W - 1));
    end

    // Busy and done flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_o <= 1'b0;
            done_o <= 1'b0;
        end else begin
            done_o <= frame_end;
            if (accept_o)       busy_o <= 1'b1;
            else if (frame_end) busy_o <= 1'b0;
        end
    end

    // Shift register and bit index: the MSB is always the current bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q <= '0;
            idx_q   <= '0;
        end else if (accept_o) begin
            shreg_q <= frame_i;
            idx_q   <= '0;
        end else if (bit_end && !frame_end) begin
            shreg_q <= shreg_q << 1;
            idx_q   <= idx_q + IDX_W'(1);
        end
    end

    // Half-bit phase toggles at each chip end
    always_ff @(posedge clk) begin
        if (!rst_n)                       phase_o <= PH_FIRST;
        else if (accept_o)                phase_o <= PH_FIRST;
        else if (busy_o && chip_last_i)   phase_o <= (phase_o == PH_FIRST) ? PH_SECOND : PH_FIRST;
    end

    assign bit_o = shreg_q[FRAME_W-1];
endmodule

// File: rtl/cmd_manchester_tx.sv
// Top: frames a command word and sends it as Manchester chips.
// Assumes: a chip length of 0 means 1. A start while busy is dropped.
module cmd_manchester_tx
    import cmtx_pkg::*;
#(
    parameter int HDR_W = 4,
    parameter int DAT_W = 8,
    parameter int STP_W = 2,
    parameter logic [HDR_W-1:0] HDR_PAT = 4'b1101,
    parameter int CNT_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic [DAT_W-1:0]        data_i,
    input  logic [CNT_W-1:0]        chip_len_i,
    output logic                    chip_o,
    output logic                    chip_stb_o,
    output logic signed [1:0]       level_o,
    output logic                    busy_o,
    output logic                    done_o
);
    localparam int FRAME_W = HDR_W + DAT_W + STP_W;

    logic [FRAME_W-1:0] frame;
    logic               accept;
    logic               chip_first;
    logic               chip_last;
    logic               cur_bit;
    half_e              phase;

    cmtx_frame_builder #(
        .HDR_W(HDR_W), .DAT_W(DAT_W), .STP_W(STP_W), .HDR_PAT(HDR_PAT)
    ) u_build (
        .data_i (data_i),
        .frame_o(frame)
    );

    cmtx_chip_timer #(.CNT_W(CNT_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (accept),
        .len_i  (chip_len_i),
        .run_i  (busy_o),
        .first_o(chip_first),
        .last_o (chip_last)
    );

    cmtx_sequencer #(.FRAME_W(FRAME_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .frame_i    (frame),
        .chip_last_i(chip_last),
        .accept_o   (accept),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .bit_o      (cur_bit),
        .phase_o    (phase)
    );

    // Output coding: chip, chip strobe and signed level, quiet when idle
    always_comb begin
        chip_o     = busy_o ? line_chip(cur_bit, phase) : 1'b0;
        chip_stb_o = chip_first;
        level_o    = busy_o ? chip_level(chip_o) : 2'sb00;
    end
endmodule

// File: rtl/cmd_manchester_tx_chk.sv
// Checker for the encoder's port timing, bound to every instance of the top.
module cmd_manchester_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic chip_o,
    input logic chip_stb_o,
    input logic busy_o,
    input logic done_o
);
    // R5: a chip strobe only inside a frame
    a_r5_stb_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        chip_stb_o |-> busy_o);

    // R4: the chip holds steady between strobes
    a_r4_chip_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !chip_stb_o) |-> $stable(chip_o));

    // R7: a frame opens with a strobe, one cycle after an idle start
    a_r7_open_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> (chip_stb_o && $past(start_i)));

    // R9: done follows the end of busy and lasts one cycle
    a_r9_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o)));

    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8: busy cannot drop without a done pulse
    a_r8_no_early_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);
endmodule

bind cmd_manchester_tx cmd_manchester_tx_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .chip_o    (chip_o),
    .chip_stb_o(chip_stb_o),
    .busy_o    (busy_o),
    .done_o    (done_o)
);

// File: tb/cmd_manchester_tx_tb_top.sv
// Sweeping bench: every data word at two chip lengths, plus corner lengths,
// mid-frame start attempts and back-to-back frames.
module cmd_manchester_tx_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int HDR_W = 4;
    localparam int DAT_W = 8;
    localparam int STP_W = 2;
    localparam logic [HDR_W-1:0] HDR_PAT = 4'b1101;
    localparam int CNT_W = 16;
    localparam int FRAME_W = HDR_W + DAT_W + STP_W;

    logic clk = 1'b0;
    logic rst_n;
    logic start_i;
    logic [DAT_W-1:0] data_i;
    logic [CNT_W-1:0] chip_len_i;
    logic chip_o, chip_stb_o, busy_o, done_o;
    logic signed [1:0] level_o;

    int n_checks = 0;
    int n_errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmd_manchester_tx #(
        .HDR_W(HDR_W), .DAT_W(DAT_W), .STP_W(STP_W),
        .HDR_PAT(HDR_PAT), .CNT_W(CNT_W)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .data_i(data_i),
        .chip_len_i(chip_len_i), .chip_o(chip_o), .chip_stb_o(chip_stb_o),
        .level_o(level_o), .busy_o(busy_o), .done_o(done_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Called at a negedge: issues a start and follows the whole frame
    task automatic run_frame(input logic [DAT_W-1:0] d, input int len, input bit inject);
        logic [FRAME_W-1:0] fr;
        int eff;
        fr  = {HDR_PAT, d, {STP_W{1'b1}}};
        eff = (len == 0) ? 1 : len;
        start_i    = 1'b1;
        data_i     = d;
        chip_len_i = CNT_W'(len);
        for (int k = 0; k < 2*FRAME_W; k++) begin
            for (int c = 0; c < eff; c++) begin
                logic b, ec;
                @(negedge clk);
                // R8: a start attempt while busy, with other data and length
                start_i = inject && (k == 5) && (c == 0);
                if (start_i) begin
                    data_i     = ~d;
                    chip_len_i = CNT_W'(eff + 2);
                end
                b  = fr[FRAME_W-1-(k/2)];
                ec = b ^ logic'(k % 2);
                // R2/R3/R8: chip value from the frame bit and the half
                check(chip_o == ec, "R2/R3/R8 chip value", int'(chip_o), int'(ec));
                // R4/R5: strobe only on the first cycle of each chip
                check(chip_stb_o == (c == 0), "R4/R5 chip strobe", int'(chip_stb_o), int'(c == 0));
                // R7: busy over the whole frame
                check(busy_o == 1'b1 && done_o == 1'b0, "R7 busy in frame",
                      int'({busy_o, done_o}), 2);
                // R6: signed level follows the chip
                check(int'(level_o) == (ec ? 1 : -1), "R6 level", int'(level_o), ec ? 1 : -1);
            end
        end
        @(negedge clk);
        start_i = 1'b0;
        // R9: done in the cycle after the last chip, busy low
        check(done_o == 1'b1 && busy_o == 1'b0, "R9 done pulse", int'({busy_o, done_o}), 1);
        check(int'(level_o) == 0 && chip_stb_o == 1'b0, "R6 idle level",
              int'(level_o), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        n_errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        start_i = 1'b0;
        data_i = '0;
        chip_len_i = CNT_W'(1);
        repeat (3) @(negedge clk);
        // R1: outputs quiet during reset
        check(!busy_o && !done_o && !chip_stb_o && !chip_o && level_o == 0,
              "R1 reset state", int'({busy_o, done_o, chip_stb_o, chip_o}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy_o && !done_o && level_o == 0, "R1 after reset",
              int'({busy_o, done_o}), 0);

        // Sweep every word at chip lengths 1 and 2
        for (int len = 1; len <= 2; len++) begin
            for (int d = 0; d < (1 << DAT_W); d++) begin
                run_frame(DAT_W'(d), len, (d % 17) == 0);
                if ((d % 4) != 3) begin
                    @(negedge clk);
                    // R9: done lasts one cycle
                    check(done_o == 1'b0 && busy_o == 1'b0, "R9 done single",
                          int'({busy_o, done_o}), 0);
                end
                // otherwise R9: the next start lands in the done cycle
            end
        end

        // R4: length 0 acts as 1; longer lengths with start attempts
        run_frame(8'hA5, 0, 1'b1);
        @(negedge clk);
        run_frame(8'h3C, 3, 1'b1);
        run_frame(8'h81, 5, 1'b1);
        run_frame(8'h00, 5, 1'b0);
        @(negedge clk);
        check(!busy_o && !done_o, "R7 idle after frames", int'({busy_o, done_o}), 0);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule